// File: doc/BRIEF.md
# Shared PLL Power Sequencer with Consumer Counting

This block sits between several consumers of one on-chip PLL (for example two USB PHY ports and a fixed-rate clock output) and the analog pieces that make the PLL run: two supply rails, a control-word write strobe, the PLL enable, and a monitor port that reports lock. A consumer claims the PLL with an enable request and gives it back with a release request. The block keeps a count of current claims. The first claim powers the rails in order, writes the control word, raises the enable and then, for consumers that need it, polls lock. The last release lowers the enable, waits for the readback to go low, and drops the rails in reverse order. Every request ends in a one-cycle done or error pulse back to the consumer that made it.

Only one request is serviced at a time. A fixed-priority arbiter picks the lowest-numbered requester while the sequencer is idle. The other requesters see `busy` and keep their request raised until their own response arrives. A failure during power-up or during the lock check undoes everything that request did. The rails are switched off again in reverse order, and the claim is taken back out of the count before the error pulse. A PLL whose readback shows it running while no claim exists is first run through the full power-down sequence and then powered up normally.

States: `S_IDLE` (waits for a request; the arbiter's choice is captured), `S_CHK` (decides the path), `S_PD_CLR` (clears the enable), `S_PD_WAIT` (polls the readback low), `S_HI_OFF` and `S_LO_OFF` (drop the second, then the first rail), `S_LO_ON` and `S_HI_ON` (raise a rail and wait for its ready), `S_CFG` (control-word strobe), `S_PLL_ON` (raises the enable), `S_LOCK` (lock poll), `S_RESP` (response pulse). Transitions:
- `S_IDLE` goes to `S_CHK` on any request.
- From `S_CHK`, an enable goes to `S_RESP` when saturated, to `S_LOCK` or `S_RESP` on the fast path, to `S_PD_CLR` for a stray PLL, and to `S_LO_ON` otherwise. A release goes to `S_RESP` (at zero, or when claims remain) or to `S_PD_CLR` (last claim).
- The power-down chain runs `S_PD_CLR` → `S_PD_WAIT` → `S_HI_OFF` → `S_LO_OFF`. From `S_LO_OFF` it goes to `S_LO_ON` when a power-up is pending, and to `S_RESP` otherwise.
- The power-up chain runs `S_LO_ON` → `S_HI_ON` → `S_CFG` → `S_PLL_ON`, then to `S_LOCK` or `S_RESP`.
- Failure exits: `S_LO_ON` to `S_LO_OFF`; `S_HI_ON` and `S_CFG` to `S_HI_OFF`; `S_LOCK` to `S_PD_CLR` or `S_RESP`.
- `S_RESP` returns to `S_IDLE`.

Top module: `pll_share_seq`

## Requirements
- R1: Power-up follows a fixed order. `sup_lo_en` rises first. `sup_hi_en` rises only after `sup_lo_rdy` has been seen high. `cfg_wr` pulses once both rails are ready. `pll_en` rises in the cycle after that pulse. `sup_hi_en` is never high while `sup_lo_en` is low.
- R2: An enable request that finds at least one claim and `pll_en_rb` high changes no rail and no enable. It completes with done, after the lock check if that consumer needs one.
- R3: An enable request that finds no claim but `pll_en_rb` high first runs the power-down sequence. No rail is raised while the readback stays high, and the request then powers up normally.
- R4: A release removes one claim. Rails and enable go off only when the count reaches zero. At rest, `sup_lo_en`, `sup_hi_en` and `pll_en` are high exactly when at least one claim exists.
- R5: Power-down clears `pll_en` first. It polls `pll_en_rb` every `PD_POLL` cycles, for at most `PD_TRIES` polls, and goes on even on timeout. It then drops `sup_hi_en` before `sup_lo_en`. `pll_en` is never high unless both rails are on.
- R6: Each consumer whose bit is set in `LOCK_USERS` (default: consumers 0 and 1) checks lock after enabling. The check drives `mon_sel` = 5'h1F and reads lock on `mon_out` bit 3, polling every `LOCK_POLL` cycles for at most `LOCK_TRIES` polls. On timeout the claim is removed, the PLL is powered down if that was the last claim, and the response is error. `mon_sel` is 0 outside the check.
- R7: If `sup_lo_rdy` is not seen within `SUP_WAIT` cycles, `sup_lo_en` drops and the request ends in error with the count restored. If `sup_hi_rdy` is not seen, `sup_hi_en` and then `sup_lo_en` drop, with the same error and count restore.
- R8: If `cfg_ok` is low at the control-word step, both rails drop in reverse order, no enable is raised, the count is restored and the response is error.
- R9: A release while the count is zero, or an enable while the count already equals `N_USERS`, returns error and changes nothing.
- R10: One request at a time. `busy` is high from the cycle after a request is taken until the response. The lowest-numbered requester wins. At most one response bit is high, and only for a consumer that is requesting.
- R11: In reset and right after it, every output is low and `mon_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_USERS | Request raised per consumer, held until its response |
| req_on | input | N_USERS | Per consumer: 1 = enable (claim), 0 = release |
| busy | output | 1 | A request is being serviced |
| rsp_done | output | N_USERS | One-cycle success pulse to the serviced consumer |
| rsp_err | output | N_USERS | One-cycle error pulse to the serviced consumer |
| sup_lo_en | output | 1 | Enable for the first (lower-voltage) rail |
| sup_lo_rdy | input | 1 | First rail is up |
| sup_hi_en | output | 1 | Enable for the second (higher-voltage) rail |
| sup_hi_rdy | input | 1 | Second rail is up |
| cfg_ok | input | 1 | Control word is valid for the present reference clock |
| cfg_wr | output | 1 | One-cycle strobe to write the PLL control word |
| pll_en | output | 1 | PLL enable |
| pll_en_rb | input | 1 | Readback of the PLL enable as seen by the PLL |
| mon_sel | output | 5 | Monitor select; 5'h1F selects the lock signal |
| mon_out | input | 4 | Monitor output; bit 3 is lock when 5'h1F is selected |

## Verification
The bound checker watches the structural ordering on every cycle:
- the second rail never runs without the first, and the enable never runs without both rails;
- the enable rises only right after the control-word strobe, and the second rail rises only after the first rail reported ready;
- the monitor select takes only 0 or 5'h1F, and the lock code appears only while the enable is high;
- responses are one-hot, go only to a requester, and come only while `busy` is high.

Only the bench's scenarios can show the counting behaviour and the rollback. These include the fast path leaving the rails alone, power staying up until the last release, saturation and release at zero, and each failure (first rail, second rail, control word, lock) restoring the count. The bench's idle-time comparison of the rails against its own claim count catches that. The stray-PLL cycle and the arbiter's priority also depend on scenario stimulus.

// File: rtl/pll_seq_pkg.sv
`timescale 1ns/1ps
package pll_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CHK,
        S_PD_CLR,
        S_PD_WAIT,
        S_HI_OFF,
        S_LO_OFF,
        S_LO_ON,
        S_HI_ON,
        S_CFG,
        S_PLL_ON,
        S_LOCK,
        S_RESP
    } seq_state_t;

    localparam logic [4:0] MON_LOCK_SEL = 5'h1F;
    localparam int         MON_LOCK_BIT = 3;

endpackage

// File: rtl/pll_req_arb.sv
`timescale 1ns/1ps
module pll_req_arb #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N-1:0] lower;

    assign lower[0] = 1'b0;
    generate
        for (genvar i = 1; i < N; i++) begin : g_chain
            assign lower[i] = lower[i-1] | req[i-1];
        end
    endgenerate

    assign grant = req & ~lower;
endmodule

// File: rtl/pll_poll_timer.sv
`timescale 1ns/1ps
module pll_poll_timer #(
    parameter int CW = 4,
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] ivl,
    input  logic [TW-1:0] lim,
    input  logic          cond,
    output logic          hit,
    output logic          expire
);
    logic [CW-1:0] tmr;
    logic [TW-1:0] tries;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr   <= '0;
            tries <= '0;
        end else if (!run) begin
            tmr   <= ivl - CW'(1);
            tries <= '0;
        end else if (tmr == '0) begin
            if (!cond) begin
                tries <= tries + TW'(1);
                tmr   <= ivl - CW'(1);
            end
        end else begin
            tmr <= tmr - CW'(1);
        end
    end

    assign hit    = run && (tmr == '0) && cond;
    assign expire = run && (tmr == '0) && !cond && (tries == lim - TW'(1));
endmodule

// File: rtl/pll_share_seq.sv
`timescale 1ns/1ps
module pll_share_seq
    import pll_seq_pkg::*;
#(
    parameter int                 N_USERS    = 3,
    parameter logic [N_USERS-1:0] LOCK_USERS = 3'b011,
    parameter int                 PD_POLL    = 4,
    parameter int                 PD_TRIES   = 10,
    parameter int                 LOCK_POLL  = 8,
    parameter int                 LOCK_TRIES = 10,
    parameter int                 SUP_WAIT   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_USERS-1:0] req_valid,
    input  logic [N_USERS-1:0] req_on,
    output logic               busy,
    output logic [N_USERS-1:0] rsp_done,
    output logic [N_USERS-1:0] rsp_err,
    output logic               sup_lo_en,
    input  logic               sup_lo_rdy,
    output logic               sup_hi_en,
    input  logic               sup_hi_rdy,
    input  logic               cfg_ok,
    output logic               cfg_wr,
    output logic               pll_en,
    input  logic               pll_en_rb,
    output logic [4:0]         mon_sel,
    input  logic [3:0]         mon_out
);
    localparam int NW    = $clog2(N_USERS + 1);
    localparam int IW    = (N_USERS > 1) ? $clog2(N_USERS) : 1;
    localparam int PMAX  = (PD_POLL > LOCK_POLL) ? PD_POLL : LOCK_POLL;
    localparam int CW    = $clog2(PMAX + 1);
    localparam int TMAX0 = (PD_TRIES > LOCK_TRIES) ? PD_TRIES : LOCK_TRIES;
    localparam int TMAX  = (TMAX0 > SUP_WAIT) ? TMAX0 : SUP_WAIT;
    localparam int TW    = $clog2(TMAX + 1);

    seq_state_t st, nxt;
    logic        st_new;
    logic [NW-1:0] cnt;
    logic [IW-1:0] sel, gidx;
    logic        sel_on, err_q, up_q;
    logic        do_inc, do_dec, set_err, set_up;
    logic [N_USERS-1:0] grant;
    logic        t_run, t_cond, t_hit, t_exp;
    logic [CW-1:0] t_ivl;
    logic [TW-1:0] t_lim;
    logic        sel_lock, lock_seen;
    logic        unused_mon;

    pll_req_arb #(.N(N_USERS)) u_arb (.req(req_valid), .grant(grant));

    always_comb begin
        gidx = '0;
        for (int i = N_USERS - 1; i >= 0; i--)
            if (grant[i]) gidx = IW'(i);
    end

    assign sel_lock   = LOCK_USERS[sel];
    assign lock_seen  = mon_out[MON_LOCK_BIT];
    assign unused_mon = ^mon_out[2:0];

    // Poll timer: one instance shared by every waiting state
    always_comb begin
        t_run  = 1'b0;
        t_ivl  = CW'(1);
        t_lim  = TW'(SUP_WAIT);
        t_cond = 1'b0;
        unique case (st)
            S_PD_WAIT: begin t_run = !st_new; t_ivl = CW'(PD_POLL);   t_lim = TW'(PD_TRIES);   t_cond = !pll_en_rb; end
            S_LOCK:    begin t_run = !st_new; t_ivl = CW'(LOCK_POLL); t_lim = TW'(LOCK_TRIES); t_cond = lock_seen;  end
            S_LO_ON:   begin t_run = !st_new; t_cond = sup_lo_rdy; end
            S_HI_ON:   begin t_run = !st_new; t_cond = sup_hi_rdy; end
            default:   ;
        endcase
    end

    pll_poll_timer #(.CW(CW), .TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(t_run), .ivl(t_ivl), .lim(t_lim),
        .cond(t_cond), .hit(t_hit), .expire(t_exp)
    );

    // Next state and per-transition actions
    always_comb begin
        nxt = st; do_inc = 1'b0; do_dec = 1'b0; set_err = 1'b0; set_up = 1'b0;
        unique case (st)
            S_IDLE: if (|req_valid) nxt = S_CHK;
            S_CHK: begin
                if (sel_on) begin
                    if (cnt == NW'(N_USERS)) begin
                        set_err = 1'b1; nxt = S_RESP;
                    end else begin
                        do_inc = 1'b1;
                        if (cnt != '0 && pll_en_rb) nxt = sel_lock ? S_LOCK : S_RESP;
                        else if (pll_en_rb) begin set_up = 1'b1; nxt = S_PD_CLR; end
                        else nxt = S_LO_ON;
                    end
                end else if (cnt == '0) begin
                    set_err = 1'b1; nxt = S_RESP;
                end else begin
                    do_dec = 1'b1;
                    nxt = (cnt == NW'(1)) ? S_PD_CLR : S_RESP;
                end
            end
            S_PD_CLR:  nxt = S_PD_WAIT;
            S_PD_WAIT: if (t_hit || t_exp) nxt = S_HI_OFF;
            S_HI_OFF:  nxt = S_LO_OFF;
            S_LO_OFF:  nxt = up_q ? S_LO_ON : S_RESP;
            S_LO_ON: begin
                if (t_hit) nxt = S_HI_ON;
                else if (t_exp) begin do_dec = 1'b1; set_err = 1'b1; nxt = S_LO_OFF; end
            end
            S_HI_ON: begin
                if (t_hit) nxt = S_CFG;
                else if (t_exp) begin do_dec = 1'b1; set_err = 1'b1; nxt = S_HI_OFF; end
            end
            S_CFG: begin
                if (cfg_ok) nxt = S_PLL_ON;
                else begin do_dec = 1'b1; set_err = 1'b1; nxt = S_HI_OFF; end
            end
            S_PLL_ON: nxt = sel_lock ? S_LOCK : S_RESP;
            S_LOCK: begin
                if (t_hit) nxt = S_RESP;
                else if (t_exp) begin
                    do_dec = 1'b1; set_err = 1'b1;
                    nxt = (cnt == NW'(1)) ? S_PD_CLR : S_RESP;
                end
            end
            S_RESP:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // State register and request bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; st_new <= 1'b1; cnt <= '0;
            sel <= '0; sel_on <= 1'b0; err_q <= 1'b0; up_q <= 1'b0;
        end else begin
            st     <= nxt;
            st_new <= (nxt != st);
            if (st == S_IDLE) begin
                sel    <= gidx;
                sel_on <= req_on[gidx];
                err_q  <= 1'b0;
            end
            if (set_err) err_q <= 1'b1;
            if (set_up) up_q <= 1'b1;
            else if (st == S_LO_ON) up_q <= 1'b0;
            if (do_inc) cnt <= cnt + NW'(1);
            else if (do_dec) cnt <= cnt - NW'(1);
        end
    end

    // Held outputs: rails and enable follow the state being entered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sup_lo_en <= 1'b0; sup_hi_en <= 1'b0; pll_en <= 1'b0;
        end else begin
            if (nxt == S_LO_ON) sup_lo_en <= 1'b1;
            else if (nxt == S_LO_OFF) sup_lo_en <= 1'b0;
            if (nxt == S_HI_ON) sup_hi_en <= 1'b1;
            else if (nxt == S_HI_OFF) sup_hi_en <= 1'b0;
            if (nxt == S_PLL_ON) pll_en <= 1'b1;
            else if (nxt == S_PD_CLR) pll_en <= 1'b0;
        end
    end

    // Pulsed outputs decoded from the present state
    always_comb begin
        busy     = (st != S_IDLE);
        cfg_wr   = (st == S_CFG);
        mon_sel  = (st == S_LOCK) ? MON_LOCK_SEL : 5'h00;
        rsp_done = '0;
        rsp_err  = '0;
        if (st == S_RESP) begin
            if (err_q) rsp_err[sel] = 1'b1;
            else       rsp_done[sel] = 1'b1;
        end
    end
endmodule

// File: rtl/pll_share_seq_chk.sv
`timescale 1ns/1ps
module pll_share_seq_chk #(
    parameter int N_USERS = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_USERS-1:0] req_valid,
    input logic               busy,
    input logic [N_USERS-1:0] rsp_done,
    input logic [N_USERS-1:0] rsp_err,
    input logic               sup_lo_en,
    input logic               sup_lo_rdy,
    input logic               sup_hi_en,
    input logic               cfg_wr,
    input logic               pll_en,
    input logic [4:0]         mon_sel
);
    assert_hi_needs_lo_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sup_hi_en |-> sup_lo_en);

    assert_hi_after_lo_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sup_hi_en) |-> $past(sup_lo_rdy));

    assert_cfg_before_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en) |-> $past(cfg_wr));

    assert_enable_needs_rails_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en |-> (sup_lo_en && sup_hi_en));

    assert_monitor_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_sel != 5'h00) |-> (mon_sel == 5'h1F && pll_en));

    assert_single_response_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_done | rsp_err) && ((rsp_done & rsp_err) == '0));

    assert_response_to_requester_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((rsp_done | rsp_err) & ~req_valid) == '0);

    assert_response_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rsp_done | rsp_err)) |-> busy);
endmodule

bind pll_share_seq pll_share_seq_chk #(.N_USERS(N_USERS)) u_chk (.*);

// File: tb/test_pll_share_seq.sv
`timescale 1ns/1ps
module test_pll_share_seq;
    localparam int         N  = 3;
    localparam logic [2:0] LK = 3'b011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [N-1:0] req_valid = '0, req_on = '0;
    logic busy, sup_lo_en, sup_hi_en, cfg_wr, pll_en;
    logic [N-1:0] rsp_done, rsp_err;
    logic [4:0] mon_sel;
    logic [3:0] mon_out;
    logic sup_lo_rdy, sup_hi_rdy, pll_en_rb;

    logic lo_fail = 0, hi_fail = 0, cfg_good = 1, lock_ok = 1, force_rb = 0;
    logic [1:0] lo_d = 0, hi_d = 0;
    logic rb_lag = 0;

    always @(posedge clk) begin
        lo_d   <= {lo_d[0], sup_lo_en & ~lo_fail};
        hi_d   <= {hi_d[0], sup_hi_en & ~hi_fail};
        rb_lag <= pll_en;
    end
    assign sup_lo_rdy = lo_d[1];
    assign sup_hi_rdy = hi_d[1];
    assign pll_en_rb  = rb_lag | force_rb;
    assign mon_out    = {pll_en & lock_ok & (mon_sel == 5'h1F), 3'b000};

    pll_share_seq i_pll_share_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on),
        .busy(busy), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .sup_lo_en(sup_lo_en), .sup_lo_rdy(sup_lo_rdy),
        .sup_hi_en(sup_hi_en), .sup_hi_rdy(sup_hi_rdy),
        .cfg_ok(cfg_good), .cfg_wr(cfg_wr), .pll_en(pll_en), .pll_en_rb(pll_en_rb),
        .mon_sel(mon_sel), .mon_out(mon_out)
    );

    int total = 0, bad = 0, mon_total = 0, mon_bad = 0;
    int cnt_m = 0;
    int lo_rises = 0;
    bit mon_seen = 0, stray_bad = 0, lo_prev = 0, finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the claim model and ordering rules
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            mon_total++;
            if (sup_hi_en && !sup_lo_en) begin
                mon_bad++; $display("FAIL R1 second rail without first actual=1 expected=0");
            end
            mon_total++;
            if (pll_en && !(sup_lo_en && sup_hi_en)) begin
                mon_bad++; $display("FAIL R5 enable without rails actual=1 expected=0");
            end
            if (!busy) begin
                mon_total++;
                if (sup_lo_en != (cnt_m > 0) || sup_hi_en != (cnt_m > 0) || pll_en != (cnt_m > 0)) begin
                    mon_bad++;
                    $display("FAIL R4 rest state actual=%0d%0d%0d expected=%0d",
                             sup_lo_en, sup_hi_en, pll_en, cnt_m > 0);
                end
            end
            if (force_rb && sup_lo_en) stray_bad = 1;
            if (mon_sel == 5'h1F) mon_seen = 1;
            if (sup_lo_en && !lo_prev) lo_rises++;
            lo_prev = sup_lo_en;
        end
    end

    task automatic predict(input int idx, input bit on, output bit e, output int nc);
        nc = cnt_m; e = 0;
        if (on) begin
            if (cnt_m == N) e = 1;
            else if (cnt_m == 0 && (lo_fail || hi_fail || !cfg_good)) e = 1;
            else if (LK[idx] && !lock_ok) e = 1;
            else nc = cnt_m + 1;
        end else begin
            if (cnt_m == 0) e = 1;
            else nc = cnt_m - 1;
        end
    endtask

    task automatic do_req(input int idx, input bit on, input string tag);
        bit e; int nc;
        predict(idx, on, e, nc);
        @(posedge clk); #1;
        req_valid[idx] = 1'b1; req_on[idx] = on;
        do @(negedge clk); while ((rsp_done | rsp_err) == '0);
        check(rsp_err[idx] == e && rsp_done[idx] == !e, tag, rsp_err[idx], e);
        check(((rsp_done | rsp_err) & ~(3'b001 << idx)) == '0, {tag, " other"},
              rsp_done | rsp_err, 3'b001 << idx);
        cnt_m = nc;
        @(posedge clk); #1;
        req_valid[idx] = 1'b0;
    endtask

    initial begin
        int r;
        repeat (3) @(negedge clk);
        check({busy, sup_lo_en, sup_hi_en, pll_en, cfg_wr} == 5'b0 && mon_sel == 0 &&
              rsp_done == 0 && rsp_err == 0, "R11 outputs in reset", busy, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        check({busy, sup_lo_en, sup_hi_en, pll_en} == 4'b0 && mon_sel == 0, "R11 after reset", busy, 0);

        // First claim by the clock-output consumer: full power-up
        do_req(2, 1, "R1 first enable");
        check(pll_en == 1, "R1 enable raised", pll_en, 1);
        check(lo_rises == 1, "R1 one rail power-up", lo_rises, 1);

        // Fast path for a lock-checking port
        r = lo_rises;
        do_req(0, 1, "R2 fast enable");
        check(lo_rises == r, "R2 rails untouched", lo_rises, r);
        check(mon_seen == 1, "R6 lock code selected", mon_seen, 1);

        do_req(1, 1, "R2 third claim");
        do_req(2, 1, "R9 enable when saturated");

        do_req(1, 0, "R4 release keeps power");
        check(pll_en == 1, "R4 enable still high", pll_en, 1);
        do_req(0, 0, "R4 release keeps power");
        do_req(2, 0, "R5 last release");
        check({sup_lo_en, sup_hi_en, pll_en} == 3'b000, "R5 all off", {sup_lo_en, sup_hi_en, pll_en}, 0);

        do_req(0, 0, "R9 release at zero");

        // Lock failure as first claim and as additional claim
        lock_ok = 0;
        do_req(0, 1, "R6 lock timeout first claim");
        check({sup_lo_en, pll_en} == 2'b00, "R6 powered down after timeout", {sup_lo_en, pll_en}, 0);
        lock_ok = 1;
        do_req(2, 1, "R6 setup claim");
        lock_ok = 0;
        do_req(1, 1, "R6 lock timeout extra claim");
        check(pll_en == 1, "R6 power kept for other claim", pll_en, 1);
        lock_ok = 1;
        do_req(2, 0, "R6 release setup claim");

        // Rail failures
        lo_fail = 1;
        do_req(2, 1, "R7 first rail failure");
        lo_fail = 0; hi_fail = 1;
        do_req(2, 1, "R7 second rail failure");
        hi_fail = 0;
        repeat (4) @(posedge clk);

        // Control word failure, then count must have been restored
        cfg_good = 0;
        do_req(2, 1, "R8 control word failure");
        cfg_good = 1;
        do_req(2, 1, "R8 enable after rollback");
        do_req(2, 0, "R8 single release powers down");

        // PLL found running without claims
        force_rb = 1;
        repeat (3) @(posedge clk);
        fork
            do_req(2, 1, "R3 stray PLL cycle");
            begin repeat (20) @(posedge clk); #1; force_rb = 0; end
        join
        check(stray_bad == 0, "R3 no rail while readback high", stray_bad, 0);
        check(pll_en == 1, "R3 powered up afterwards", pll_en, 1);

        // Priority and busy: consumer 0 enable beats consumer 2 release
        begin
            bit e0, e2; int n0, n2;
            predict(0, 1, e0, n0);
            @(posedge clk); #1;
            req_valid = 3'b101; req_on = 3'b001;
            @(negedge clk); @(negedge clk);
            check(busy == 1, "R10 busy while serving", busy, 1);
            do @(negedge clk); while ((rsp_done | rsp_err) == '0);
            check(rsp_done == 3'b001 && rsp_err == 0 && !e0, "R10 lowest index first", rsp_done, 1);
            cnt_m = n0;
            @(posedge clk); #1; req_valid[0] = 0;
            predict(2, 0, e2, n2);
            do @(negedge clk); while ((rsp_done | rsp_err) == '0);
            check(rsp_done == 3'b100 && rsp_err == 0 && !e2, "R10 waiting requester served", rsp_done, 4);
            cnt_m = n2;
            @(posedge clk); #1; req_valid[2] = 0;
        end
        check(pll_en == 1, "R4 claim of consumer 0 remains", pll_en, 1);
        do_req(0, 0, "R4 final release");
        repeat (4) @(negedge clk);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total + mon_total + 1, bad + mon_bad + 1);
            $finish;
        end
    end
endmodule